// File: doc/BRIEF.md
# Pushbutton Power-State Controller

This block is the power-state sequencer of a battery-powered device. It watches a clean, active-low pushbutton level, a flag that says external supply is present, a flag that says the regulated output is under its lockout threshold, and a flag that says the output has fallen low enough to count as a power-on reset. From these it decides when two regulators are switched on or off. It raises a one-cycle sequence-start pulse whenever a power-up begins and reports its state as a 3-bit code.

All durations are counted in ticks of one shared prescaler. The short button-status delay, the power-up press, the one-second power-down wait, the long hard-reset hold and the power-up dwell are each a parameter given in ticks, so a bench can shrink them. Every timer restarts from zero as soon as the condition it is timing goes away. A long hold while running forces a hard reset. After a hard reset, a press only counts once the button has been let go and pressed again. Losing external power takes the device down, and if that power comes back before the wait ends, the device powers up again by itself.

Top module: `pbpwr_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the state is hard-reset (code 0), both regulator enables are low, and the status and sequence-start outputs are low.
- R2: In hard-reset (0) or power-off (1), a button held low (btn_n = 0) for T_PRESS ticks enters button power-up (code 3). A shorter press leaves the state unchanged.
- R3: A press that began before the power-down that led to hard-reset is ignored. The button must be seen high before a new press is timed.
- R4: On entering either power-up state (3 or 4), seq_start is high for exactly one cycle and both enables go high. After T_PUP ticks in that state the machine moves to power-on (code 2).
- R5: In power-on, reg_a_en and reg_b_en follow ena_a_in and ena_b_in with one cycle of delay.
- R6: btn_stat rises after the button has been held low for T_STAT ticks in power-on, and it is never high outside power-on.
- R7: Holding the button low for T_HOLD ticks in power-on enters the hard-reset power-down state (code 5). In power-down and power-off states (1, 5, 6) both enables are low.
- R8: State 5 always moves to hard-reset (0) after T_PDN ticks, whatever ext_ok is. A present ext_ok never leaves hard-reset.
- R9: In power-on, out_uvlo high enters the supply-loss power-down state (code 6). If out_por is high as well, the machine enters state 5 instead. out_por high in state 6 also moves to state 5.
- R10: State 6 moves to power-off (1) after T_PDN ticks. If ext_ok is high in power-off, the next state is external power-up (code 4), so the machine passes through state 1 for one cycle.
- R11: In power-off with ext_ok low, an enable input high while out_uvlo is low moves to power-on, and the enables follow the inputs. With out_uvlo high the machine stays in power-off.
- R12: The state codes are hard-reset 0, power-off 1, power-on 2, button power-up 3, external power-up 4, hard-reset power-down 5, supply-loss power-down 6. No other code appears.
- R13: A timed hold that is interrupted for even one cycle starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Debounced pushbutton, low when pressed |
| ext_ok | input | 1 | External supply valid |
| out_uvlo | input | 1 | Regulated output under lockout threshold |
| out_por | input | 1 | Regulated output low enough to count as power-on reset |
| ena_a_in | input | 1 | Requested enable for regulator A |
| ena_b_in | input | 1 | Requested enable for regulator B |
| reg_a_en | output | 1 | Registered enable for regulator A |
| reg_b_en | output | 1 | Registered enable for regulator B |
| seq_start | output | 1 | One-cycle pulse when a power-up sequence begins |
| btn_stat | output | 1 | Button-held status while powered on |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is the automatic return from a supply-loss power-down. The stimulus has to run the machine through a button power-up into power-on, then drop the supply and restore ext_ok during the one-second wait. The machine must then be seen in external power-up instead of power-off, because the power-off visit lasts a single cycle. The lockout after a hard reset takes a similar path. The button stays low from the long hold through the whole power-down, and the state must still be hard-reset after a further stretch longer than a valid press. Timer lengths are scaled down, and each sample lands in the middle of a window that is wide enough for any tick phase.

// File: rtl/pbpwr_pkg.sv
package pbpwr_pkg;

  typedef enum logic [2:0] {
    ST_HR   = 3'd0,
    ST_OFF  = 3'd1,
    ST_ON   = 3'd2,
    ST_PUPB = 3'd3,
    ST_PUPX = 3'd4,
    ST_PDNH = 3'd5,
    ST_PDNS = 3'd6
  } pst_e;

  localparam int NTMR     = 5;
  localparam int TM_PRESS = 0;
  localparam int TM_STAT  = 1;
  localparam int TM_HOLD  = 2;
  localparam int TM_PDN   = 3;
  localparam int TM_PUP   = 4;

  function automatic logic is_pup(input pst_e s);
    return (s == ST_PUPB) || (s == ST_PUPX);
  endfunction

  function automatic logic is_pdn(input pst_e s);
    return (s == ST_PDNH) || (s == ST_PDNS);
  endfunction

endpackage

// File: rtl/pbpwr_tick.sv
module pbpwr_tick #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic tick_q;
  assign tick = tick_q;

  generate
    if (DIV <= 1) begin : g_every
      always_ff @(posedge clk) begin
        tick_q <= !rst;
      end
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_q <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
          cnt    <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          tick_q <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pbpwr_hold.sv
module pbpwr_hold #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && (cnt != LIM)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == LIM);
endmodule

// File: rtl/pbpwr_fsm.sv
module pbpwr_fsm
  import pbpwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            btn_n,
  input  logic            ext_ok,
  input  logic            out_uvlo,
  input  logic            out_por,
  input  logic            ena_a_in,
  input  logic            ena_b_in,
  input  logic [NTMR-1:0] done,
  output logic [NTMR-1:0] run,
  output logic            reg_a_en,
  output logic            reg_b_en,
  output logic            seq_start,
  output logic            btn_stat,
  output logic [2:0]      state_o
);
  pst_e st_q, st_prev, st_d;
  logic armed;
  logic fresh;

  assign fresh = (st_q != st_prev);

  always_comb begin
    run           = '0;
    run[TM_PRESS] = !btn_n && armed && ((st_q == ST_HR) || (st_q == ST_OFF));
    run[TM_STAT]  = !btn_n && (st_q == ST_ON);
    run[TM_HOLD]  = !btn_n && (st_q == ST_ON);
    run[TM_PDN]   = is_pdn(st_q) && !fresh;
    run[TM_PUP]   = is_pup(st_q) && !fresh;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HR: begin
        if (done[TM_PRESS]) st_d = ST_PUPB;
      end
      ST_OFF: begin
        if (ext_ok)                                   st_d = ST_PUPX;
        else if ((ena_a_in || ena_b_in) && !out_uvlo) st_d = ST_ON;
        else if (done[TM_PRESS])                      st_d = ST_PUPB;
      end
      ST_PUPB, ST_PUPX: begin
        if (out_por)           st_d = ST_PDNH;
        else if (done[TM_PUP]) st_d = ST_ON;
      end
      ST_ON: begin
        if (out_por)            st_d = ST_PDNH;
        else if (out_uvlo)      st_d = ST_PDNS;
        else if (done[TM_HOLD]) st_d = ST_PDNH;
      end
      ST_PDNH: begin
        if (done[TM_PDN]) st_d = ST_HR;
      end
      ST_PDNS: begin
        if (out_por)           st_d = ST_PDNH;
        else if (done[TM_PDN]) st_d = ST_OFF;
      end
      default: st_d = ST_HR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HR;
      st_prev   <= ST_HR;
      armed     <= 1'b0;
      reg_a_en  <= 1'b0;
      reg_b_en  <= 1'b0;
      seq_start <= 1'b0;
      btn_stat  <= 1'b0;
    end else begin
      st_q      <= st_d;
      st_prev   <= st_q;
      if ((st_d == ST_PDNH) && (st_q != ST_PDNH)) armed <= 1'b0;
      else if (btn_n)                             armed <= 1'b1;
      reg_a_en  <= is_pup(st_d) || ((st_d == ST_ON) && ena_a_in);
      reg_b_en  <= is_pup(st_d) || ((st_d == ST_ON) && ena_b_in);
      seq_start <= is_pup(st_d) && (st_d != st_q);
      btn_stat  <= (st_d == ST_ON) && done[TM_STAT];
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/pbpwr_ctrl.sv
module pbpwr_ctrl
  import pbpwr_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned T_STAT   = 50,
  parameter int unsigned T_PRESS  = 400,
  parameter int unsigned T_PDN    = 1000,
  parameter int unsigned T_HOLD   = 5000,
  parameter int unsigned T_PUP    = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_n,
  input  logic       ext_ok,
  input  logic       out_uvlo,
  input  logic       out_por,
  input  logic       ena_a_in,
  input  logic       ena_b_in,
  output logic       reg_a_en,
  output logic       reg_b_en,
  output logic       seq_start,
  output logic       btn_stat,
  output logic [2:0] state_o
);
  localparam int unsigned LIMS [NTMR] = '{T_PRESS, T_STAT, T_HOLD, T_PDN, T_PUP};

  logic            tick;
  logic [NTMR-1:0] run;
  logic [NTMR-1:0] done;

  pbpwr_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      pbpwr_hold #(.LIMIT(LIMS[i])) u_hold (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (run[i]),
        .done (done[i])
      );
    end
  endgenerate

  pbpwr_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .btn_n     (btn_n),
    .ext_ok    (ext_ok),
    .out_uvlo  (out_uvlo),
    .out_por   (out_por),
    .ena_a_in  (ena_a_in),
    .ena_b_in  (ena_b_in),
    .done      (done),
    .run       (run),
    .reg_a_en  (reg_a_en),
    .reg_b_en  (reg_b_en),
    .seq_start (seq_start),
    .btn_stat  (btn_stat),
    .state_o   (state_o)
  );
endmodule

// File: rtl/pbpwr_ctrl_chk.sv
module pbpwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       btn_n,
  input logic       ext_ok,
  input logic       reg_a_en,
  input logic       reg_b_en,
  input logic       seq_start,
  input logic       btn_stat,
  input logic [2:0] state_o
);
  // R12: only the seven defined codes appear
  a_r12_legal_code: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd6);

  // R4: the sequence pulse coincides with a fresh entry into a power-up state
  a_r4_seq_on_entry: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> ((state_o == 3'd3 || state_o == 3'd4) && state_o != $past(state_o)));

  // R7: no regulator is enabled while off or powering down
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 || state_o == 3'd5 || state_o == 3'd6) |-> (!reg_a_en && !reg_b_en));

  // R8: leaving the hard-reset power-down always lands in hard-reset
  a_r8_pdnh_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> state_o == 3'd0);

  // R10: power-off with supply present lasts one cycle and goes to external power-up
  a_r10_off_bounce: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'd1 && $past(ext_ok)) |-> state_o == 3'd4);

  // R6: button status is confined to power-on
  a_r6_stat_on_only: assert property (@(posedge clk) disable iff (rst)
    btn_stat |-> state_o == 3'd2);

  // R2: button power-up is only entered while the button is pressed
  a_r2_pupb_by_press: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> !$past(btn_n));
endmodule

bind pbpwr_ctrl pbpwr_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .btn_n     (btn_n),
  .ext_ok    (ext_ok),
  .reg_a_en  (reg_a_en),
  .reg_b_en  (reg_b_en),
  .seq_start (seq_start),
  .btn_stat  (btn_stat),
  .state_o   (state_o)
);

// File: tb/test_pbpwr_ctrl.sv
module test_pbpwr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_n = 1'b1, ext_ok = 1'b0, out_uvlo = 1'b1, out_por = 1'b0;
  logic       ena_a_in = 1'b0, ena_b_in = 1'b0;
  logic       reg_a_en, reg_b_en, seq_start, btn_stat;
  logic [2:0] state_o;

  int n_chk = 0, n_bad = 0;
  int seq_hi = 0, seq_rise = 0;
  logic seq_prev = 1'b0;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;

  pbpwr_ctrl #(
    .TICK_DIV(4), .T_STAT(2), .T_PRESS(3), .T_PDN(5), .T_HOLD(8), .T_PUP(4)
  ) i_pbpwr_ctrl (
    .clk(clk), .rst(rst), .btn_n(btn_n), .ext_ok(ext_ok),
    .out_uvlo(out_uvlo), .out_por(out_por),
    .ena_a_in(ena_a_in), .ena_b_in(ena_b_in),
    .reg_a_en(reg_a_en), .reg_b_en(reg_b_en),
    .seq_start(seq_start), .btn_stat(btn_stat), .state_o(state_o)
  );

  // inputs {btn_n,ext,uvlo,por,ena_a,ena_b} | wait | state | {a,b,stat} | req
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {6'b101000, 8'd4,  3'd0, 3'b000, 4'd1 },  // R1 idle after reset
    {6'b001000, 8'd6,  3'd0, 3'b000, 4'd2 },  // R2 short press: no change
    {6'b001000, 8'd10, 3'd3, 3'b110, 4'd4 },  // R4 press done, power-up, both on
    {6'b100011, 8'd24, 3'd2, 3'b110, 4'd4 },  // R4 dwell over, power-on
    {6'b100010, 8'd2,  3'd2, 3'b100, 4'd5 },  // R5 enables follow inputs
    {6'b000010, 8'd4,  3'd2, 3'b100, 4'd6 },  // R6 status not yet
    {6'b100010, 8'd1,  3'd2, 3'b100, 4'd13},  // R13 one-cycle release
    {6'b000010, 8'd4,  3'd2, 3'b100, 4'd13},  // R13 timer restarted: no status
    {6'b000010, 8'd8,  3'd2, 3'b101, 4'd6 },  // R6 status raised
    {6'b000010, 8'd24, 3'd5, 3'b000, 4'd7 },  // R7 long hold: power-down
    {6'b000010, 8'd24, 3'd0, 3'b000, 4'd8 },  // R8 to hard-reset
    {6'b000010, 8'd20, 3'd0, 3'b000, 4'd3 },  // R3 held press ignored
    {6'b100010, 8'd2,  3'd0, 3'b000, 4'd3 },  // R3 release
    {6'b000010, 8'd16, 3'd3, 3'b110, 4'd2 },  // R2 new press accepted
    {6'b100001, 8'd30, 3'd2, 3'b010, 4'd5 },  // R5 power-on, only B
    {6'b101001, 8'd2,  3'd6, 3'b000, 4'd9 },  // R9 supply loss
    {6'b110001, 8'd30, 3'd4, 3'b110, 4'd10},  // R10 auto return via power-off
    {6'b110011, 8'd30, 3'd2, 3'b110, 4'd4 },  // R4 external power-up done
    {6'b111111, 8'd2,  3'd5, 3'b000, 4'd9 },  // R9 por overrides
    {6'b110011, 8'd30, 3'd0, 3'b000, 4'd8 },  // R8 hard-reset despite ext_ok
    {6'b010011, 8'd16, 3'd3, 3'b110, 4'd2 },  // R2 press from hard-reset
    {6'b100011, 8'd30, 3'd2, 3'b110, 4'd4 },  // R4 power-on
    {6'b101011, 8'd30, 3'd1, 3'b000, 4'd10},  // R10 no ext: rests in power-off
    {6'b101011, 8'd10, 3'd1, 3'b000, 4'd11},  // R11 uvlo holds power-off
    {6'b100001, 8'd2,  3'd2, 3'b010, 4'd11}   // R11 enable input wakes it
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (seq_start) seq_hi++;
      if (seq_start && !seq_prev) seq_rise++;
    end
    seq_prev = seq_start;
  end

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {state,a,b,stat}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", {state_o, reg_a_en, reg_b_en, btn_stat}, 6'b000000);
    chk_int("R1 seq", int'(seq_start), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {btn_n, ext_ok, out_uvlo, out_por, ena_a_in, ena_b_in} = VEC[i][23:18];
      repeat (int'(VEC[i][17:10])) @(negedge clk);
      chk($sformatf("R%0d vec%0d", VEC[i][3:0], i),
          {state_o, reg_a_en, reg_b_en, btn_stat}, VEC[i][9:4]);
    end

    // R4: four power-ups seen, each pulse exactly one cycle
    chk_int("R4 pulses", seq_rise, 4);
    chk_int("R4 width", seq_hi, 4);

    // R1: reset from power-on
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid", {state_o, reg_a_en, reg_b_en, btn_stat}, 6'b000000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", {state_o, reg_a_en, reg_b_en, btn_stat}, 6'b000000);
    chk_int("R1 seq after", int'(seq_start), 0);

    finish_run();
  end
endmodule